// File: doc/BRIEF.md
# Value-Cache Bus Transition Encoder

This block cuts the number of line transitions on a wide chip-to-chip data bus. A transmit side and a receive side each keep a small table of words sent recently. When a new word is already in the transmit table, the bus is not driven with the word. Instead, exactly one bus line is inverted, and a separate flag line says that a table hit took place. The position of the inverted line is the index of the table entry that matched. When the word is not in the table, it goes onto the bus unchanged with the flag low. Both tables then store it in the same slot, which a round-robin pointer picks.

The receive side keeps the last bus value it took. On a hit it XORs that value with the new bus value to find the inverted line, and reads its own table at that index. Because both tables are written by the same rule, on the same transfers and in the same order, they always hold the same contents. The word side has a valid/ready input handshake and a valid/ready output handshake. A stall at the output freezes the whole link, so no bus line moves while the link waits.

Top module: `vcbus_link`

## Requirements
- R1: After reset, the bus lines, the hit flag, the bus strobe and `out_valid` are all 0, and `in_ready` is 1.
- R2: A word that misses in the table is driven onto `bus_data` unchanged, with `bus_hit` at 0, one cycle after it is accepted.
- R3: A word that hits is sent by inverting exactly one line of `bus_data` relative to the previous transfer, with `bus_hit` at 1. The inverted line's position equals the matching entry's index.
- R4: Words leave on `out_data` in the order in which they were accepted, each equal to the accepted word, two cycles after acceptance when no stall occurs.
- R5: Missed words fill table entries in round-robin order, starting at entry 0 after reset.
- R6: A hit changes neither the table contents nor the round-robin pointer.
- R7: An entry never written since reset never produces a hit, whatever its stored value, including the word 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `bus_data`, `bus_hit`, `bus_strobe` and `out_data` hold their values.
- R9: The table has as many entries as the word has bits (parameter `W`). After `W` misses the pointer wraps to entry 0, and the oldest word is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Link can accept a word this cycle |
| in_data | input | W | Word to send |
| out_valid | output | 1 | Decoded word valid |
| out_ready | input | 1 | Consumer accepts the decoded word |
| out_data | output | W | Decoded word |
| bus_data | output | W | Encoded bus lines between the two ends |
| bus_hit | output | 1 | Flag line: current transfer is a table hit |
| bus_strobe | output | 1 | A transfer is present on the bus |

## Verification
Suppose the two tables diverge, for example through a pointer that moved on a hit or wrapped at the wrong count. Nothing may show on the bus itself. It shows up as a wrong `out_data` word at the first later hit on a corrupted entry, which can come many transfers after the fault. A model of the transmit table in the bench therefore predicts each bus value exactly, including which line must toggle. A pointer or fill-order fault is then caught on the first transfer that uses it, not only when a decoded word finally differs. Random streams from a small value pool force hits, wraparound and overwrite of old entries, under random output stalls.

// File: rtl/vcbus_pkg.sv
package vcbus_pkg;

  // index of the lowest set bit; 0 when no bit is set
  function automatic int unsigned lowest_one(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/vc_store.sv
module vc_store #(
  parameter int W     = 32,
  parameter int DEPTH = W,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [W-1:0]              wr_data,
  output logic [DEPTH-1:0][W-1:0]   ent,
  output logic [DEPTH-1:0]          vld
);

  logic [DEPTH-1:0][W-1:0] ent_q, ent_d;
  logic [DEPTH-1:0]        vld_q, vld_d;
  logic [IW-1:0]           ptr_q, ptr_d;

  always_comb begin
    ent_d = ent_q;
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (wr_en) begin
      ent_d[ptr_q] = wr_data;
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == IW'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  // data array carries no reset; valid bits guard it
  always_ff @(posedge clk) begin
    if (wr_en) ent_q <= ent_d;
  end

  assign ent = ent_q;
  assign vld = vld_q;

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q) && $stable(vld_q));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(ptr_q)]);

endmodule

// File: rtl/vc_encoder.sv
module vc_encoder
  import vcbus_pkg::*;
#(
  parameter int W    = 32,
  localparam int IW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic [W-1:0]  bus_q,
  output logic          hit_q,
  output logic          stb_q
);

  logic [W-1:0][W-1:0] ent;
  logic [W-1:0]        vld;
  logic [W-1:0]        match;
  logic                hit;
  logic [IW-1:0]       hit_idx;
  logic [W-1:0]        bus_d;
  logic                hit_d, stb_d;
  logic                wr_en;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_cmp
      assign match[gi] = vld[gi] && (ent[gi] == in_data);
    end
  endgenerate

  assign hit     = |match;
  assign hit_idx = IW'(lowest_one(64'(match)));
  assign wr_en   = adv && in_valid && !hit;

  vc_store #(.W(W), .DEPTH(W)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(in_data),
    .ent    (ent),
    .vld    (vld)
  );

  always_comb begin
    bus_d = bus_q;
    hit_d = hit_q;
    stb_d = stb_q;
    if (adv) begin
      stb_d = in_valid;
      if (in_valid) begin
        hit_d = hit;
        bus_d = hit ? (bus_q ^ (W'(1) << hit_idx)) : in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      hit_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      bus_q <= bus_d;
      hit_q <= hit_d;
      stb_q <= stb_d;
    end
  end

  // R3
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && hit) |=> ($countones(bus_q ^ $past(bus_q)) == 1) && hit_q);

  // R2
  miss_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && !hit) |=> (bus_q == $past(in_data)) && !hit_q);

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(bus_q) && $stable(stb_q) && $stable(hit_q));

endmodule

// File: rtl/vc_decoder.sv
module vc_decoder
  import vcbus_pkg::*;
#(
  parameter int W    = 32,
  localparam int IW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [W-1:0]  bus,
  input  logic          hit,
  input  logic          stb,
  output logic          out_valid_q,
  output logic [W-1:0]  out_data_q
);

  logic [W-1:0][W-1:0] ent;
  logic [W-1:0]        vld;
  logic [W-1:0]        prev_q, prev_d;
  logic [W-1:0]        diff;
  logic [IW-1:0]       idx;
  logic [W-1:0]        word;
  logic                take;
  logic                ov_d;
  logic [W-1:0]        od_d;

  assign take = adv && stb;
  assign diff = bus ^ prev_q;
  assign idx  = IW'(lowest_one(64'(diff)));
  assign word = hit ? ent[idx] : bus;

  vc_store #(.W(W), .DEPTH(W)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (take && !hit),
    .wr_data(bus),
    .ent    (ent),
    .vld    (vld)
  );

  always_comb begin
    ov_d   = out_valid_q;
    od_d   = out_data_q;
    prev_d = prev_q;
    if (adv) ov_d = stb;
    if (take) begin
      od_d   = word;
      prev_d = bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      prev_q      <= '0;
    end else begin
      out_valid_q <= ov_d;
      out_data_q  <= od_d;
      prev_q      <= prev_d;
    end
  end

  // R3 R7: a hit arrives as one toggled line that names a written entry
  hit_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit) |-> $onehot(diff) && vld[idx]);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_data_q) && $stable(prev_q));

endmodule

// File: rtl/vcbus_link.sv
module vcbus_link #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [W-1:0]  bus_data,
  output logic          bus_hit,
  output logic          bus_strobe
);

  logic adv;

  // the whole link advances only when the output register can move
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  vc_encoder #(.W(W)) i_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_valid(in_valid),
    .in_data (in_data),
    .bus_q   (bus_data),
    .hit_q   (bus_hit),
    .stb_q   (bus_strobe)
  );

  vc_decoder #(.W(W)) i_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .bus        (bus_data),
    .hit        (bus_hit),
    .stb        (bus_strobe),
    .out_valid_q(out_valid),
    .out_data_q (out_data)
  );

  // R8
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

  // R4
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bus_strobe) |=> out_valid);

endmodule

// File: tb/test_vcbus_link.sv
module test_vcbus_link;

  localparam int W = 32;

  typedef struct {
    logic         hit;
    logic [W-1:0] bus;
    string        tag;
  } bus_item_t;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_data;
  logic [W-1:0] bus_data;
  logic         bus_hit;
  logic         bus_strobe;

  int checks;
  int errors;
  bit stall_en;
  bit done;

  bus_item_t    bq[$];
  logic [W-1:0] dq[$];

  // transmit-table model
  logic [W-1:0] mc[W];
  bit           mv[W];
  int           mptr;
  logic [W-1:0] mbus;

  vcbus_link #(.W(W)) i_vcbus_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .bus_data  (bus_data),
    .bus_hit   (bus_hit),
    .bus_strobe(bus_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] w, input string tag);
    bus_item_t it;
    int idx;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    idx = -1;
    for (int i = W - 1; i >= 0; i--)
      if (mv[i] && mc[i] == w) idx = i;
    if (idx >= 0) begin
      it.hit = 1'b1;
      mbus   = mbus ^ (W'(1) << idx);
    end else begin
      it.hit   = 1'b0;
      mbus     = w;
      mc[mptr] = w;
      mv[mptr] = 1'b1;
      mptr     = (mptr + 1) % W;
    end
    it.bus = mbus;
    it.tag = tag;
    bq.push_back(it);
    dq.push_back(w);
    @(posedge clk);
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // output ready, changed away from both edges
  always @(posedge clk) begin
    #2;
    out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor
  logic [W-1:0] mon_prev;
  bit           was_stalled;
  logic [W-1:0] sv_out, sv_bus;
  logic         sv_hit, sv_stb;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled) begin
        // R8
        check(out_data == sv_out && bus_data == sv_bus && bus_hit == sv_hit &&
              bus_strobe == sv_stb, "R8 hold", out_data, sv_out);
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R8 in_ready", W'(in_ready), '0);
      end
      was_stalled = out_valid && !out_ready;
      sv_out = out_data; sv_bus = bus_data; sv_hit = bus_hit; sv_stb = bus_strobe;

      if (bus_strobe && in_ready) begin
        if (bq.size() == 0) begin
          check(1'b0, "R4 unexpected bus transfer", bus_data, '0);
        end else begin
          bus_item_t e;
          e = bq.pop_front();
          if (e.hit) begin
            // R3 R5 R6 R9
            check(bus_hit == 1'b1, {"R3 hit flag ", e.tag}, W'(bus_hit), 1);
            check($countones(bus_data ^ mon_prev) == 1, {"R3 one toggle ", e.tag},
                  bus_data ^ mon_prev, e.bus ^ mon_prev);
            check(bus_data == e.bus, {"R3 R5 toggle position ", e.tag}, bus_data, e.bus);
          end else begin
            // R2 R7
            check(bus_hit == 1'b0, {"R2 miss flag ", e.tag}, W'(bus_hit), 0);
            check(bus_data == e.bus, {"R2 raw word ", e.tag}, bus_data, e.bus);
          end
          mon_prev = bus_data;
        end
      end

      if (out_valid && out_ready) begin
        if (dq.size() == 0) begin
          check(1'b0, "R4 unexpected output", out_data, '0);
        end else begin
          logic [W-1:0] x;
          x = dq.pop_front();
          check(out_data == x, "R4 decoded word", out_data, x);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    stall_en = 1'b0; out_ready = 1'b1;
    in_valid = 1'b0; in_data = '0;
    mptr = 0; mbus = '0; mon_prev = '0; was_stalled = 1'b0;
    for (int i = 0; i < W; i++) begin mv[i] = 1'b0; mc[i] = '0; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(bus_data == '0 && !bus_hit && !bus_strobe && !out_valid && in_ready,
          "R1 reset state", bus_data, '0);

    // directed: invalid entries, fill order, hits leave pointer alone
    send('0, "R7 zero after reset");
    send(32'h5, "R5 entry1");
    send('0, "R5 hit entry0");
    send(32'h5, "R6 hit entry1");
    send(32'h7, "R6 next entry2");
    send(32'h5, "R6 hit again");
    // fill up to wrap
    for (int i = 0; i < W - 3; i++) send(32'h100 + i, "R9 fill");
    send(32'hDEAD_BEEF, "R9 overwrite entry0");
    send('0, "R9 evicted word misses");
    send(32'h7, "R9 surviving entry hits");
    send(32'hDEAD_BEEF, "R9 new entry0 hits");
    idle;
    repeat (4) @(negedge clk);

    // random stream with repeats and stalls
    stall_en = 1'b1;
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] v;
      v = ($urandom_range(0, 47) * 32'h0101_0101) ^ 32'h3C00_00A5;
      send(v, "R3 random");
      if ($urandom_range(0, 7) == 0) idle;
    end
    idle;
    stall_en = 1'b0;
    repeat (10) @(negedge clk);
    // R4: everything accepted has come out
    check(bq.size() == 0 && dq.size() == 0, "R4 drained", W'(dq.size()), '0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule